// File: doc/BRIEF.md
# Receive Queue with Per-Character Error Status

This block is the buffer between a serial receiver and the host. It holds up to 64 received characters. Each character carries three error marks: break, framing and parity. The receiver pushes a character and its marks through the write port. The host sees the oldest character directly on the read outputs and pops it with a one-cycle read strobe.

Two views of error state are kept. The head marks show the three flags of the character now at the front. The aggregate flag is raised while any stored character carries at least one mark. The aggregate flag comes from a live count of errored entries, not from a scan of the storage. It therefore drops in the same cycle that the last errored character is popped. The block also reports fill level, empty and full.

Top module: `rx_err_fifo`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) leaves level 0, empty 1, full 0, err_any 0, head flags 0 and rd_data 0.
- R2: Characters leave in the order they were accepted. rd_data shows the front character with no read latency. Capacity is 64 entries of 8-bit data.
- R3: head_brk, head_frm and head_par equal the break, framing and parity marks that were written with the character currently at the front.
- R4: An accepted read moves the front to the next character in the edge where rd_en is sampled high. The data and head flags then show that next character.
- R5: While empty is high, rd_data and all three head flags are zero.
- R6: err_any is high in every cycle in which at least one stored character has any of its three marks set.
- R7: err_any falls only in the cycle after the last errored character is read. Reading clean characters while an errored one remains leaves it high.
- R8: A write of an errored character together with a read of an errored front character leaves the errored-entry count, and so err_any, unchanged.
- R9: full is high at 64 stored entries. A write while full is discarded, and that character never appears at the read side.
- R10: A read while empty is ignored: no pointer or level change, and rd_data stays zero.
- R11: level equals the number of stored characters. An accepted write and an accepted read in the same cycle leave level unchanged.
- R12: A reset in the middle of operation drops all stored characters and clears err_any.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Push strobe from the receiver |
| wr_data | input | 8 | Character to store |
| wr_brk | input | 1 | Break mark for the pushed character |
| wr_frm | input | 1 | Framing mark for the pushed character |
| wr_par | input | 1 | Parity mark for the pushed character |
| rd_en | input | 1 | Pop strobe from the host |
| rd_data | output | 8 | Front character, zero when empty |
| head_brk | output | 1 | Break mark of the front character |
| head_frm | output | 1 | Framing mark of the front character |
| head_par | output | 1 | Parity mark of the front character |
| err_any | output | 1 | High while any stored character is errored |
| level | output | 7 | Number of stored characters |
| empty | output | 1 | No characters stored |
| full | output | 1 | 64 characters stored |

## Verification
The bench targets the cycle in which the last errored character is popped. If the count is decremented on the wrong entry, or not at all, err_any either stays high forever or drops while a bad character is still queued. It drives a simultaneous errored push and errored pop. A counter that favours one side there drifts by one, and the aggregate flag then lies from then on. It pushes into a full queue and pops an empty one. A design that lets either through would show a stray character, a wrapped level or head flags left over from a stale slot. A reset with errored entries still stored checks that the count is cleared together with the pointers.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rxq_err_t;

    localparam int unsigned ERR_W = $bits(rxq_err_t);

    function automatic logic rxq_is_bad(input rxq_err_t e);
        return e.brk | e.frm | e.par;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned EW    = 11,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [EW-1:0] rdata
);

    logic [EW-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slot_q[waddr] <= wdata;
        end
    end

    assign rdata = slot_q[raddr];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          full
);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [LW-1:0] level;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty  = (st_q.level == '0);
    assign full   = (st_q.level == LW'(DEPTH));
    assign wr_ptr = st_q.wr_ptr;
    assign rd_ptr = st_q.rd_ptr;
    assign level  = st_q.level;

    always_comb begin
        st_d  = st_q;
        wr_ok = wr_en && !full;
        rd_ok = rd_en && !empty;
        if (wr_ok) begin
            st_d.wr_ptr = bump(st_q.wr_ptr);
        end
        if (rd_ok) begin
            st_d.rd_ptr = bump(st_q.rd_ptr);
        end
        unique case ({wr_ok, rd_ok})
            2'b10:   st_d.level = st_q.level + LW'(1);
            2'b01:   st_d.level = st_q.level - LW'(1);
            default: st_d.level = st_q.level;
        endcase
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R11
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        full && wr_en && !rd_en |=> $stable(level) && $stable(wr_ptr));

    // R10
    empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        empty && rd_en && !wr_en |=> $stable(rd_ptr) && $stable(level));

    // R11
    both_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ok && rd_ok |=> $stable(level));

endmodule

// File: rtl/rxq_errcnt.sv
module rxq_errcnt #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          any
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case ({inc, dec})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign any = (st_q.cnt != '0);

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        inc && dec |=> $stable(cnt));

    // R6
    cnt_up_chk: assert property (@(posedge clk) disable iff (rst)
        inc && !dec |=> cnt == $past(cnt) + CW'(1));

    // R7
    cnt_down_chk: assert property (@(posedge clk) disable iff (rst)
        dec && !inc |=> cnt == $past(cnt) - CW'(1));

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned LW    = $clog2(DEPTH + 1),
    localparam int unsigned EW    = DATA_W + ERR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_brk,
    input  logic              wr_frm,
    input  logic              wr_par,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              head_brk,
    output logic              head_frm,
    output logic              head_par,
    output logic              err_any,
    output logic [LW-1:0]     level,
    output logic              empty,
    output logic              full
);

    logic          wr_ok, rd_ok;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [EW-1:0] wr_word, head_word;
    logic [LW-1:0] bad_cnt;
    rxq_err_t      wr_err, head_err;
    logic          cnt_any;

    assign wr_err  = '{brk: wr_brk, frm: wr_frm, par: wr_par};
    assign wr_word = {wr_err, wr_data};

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_ok  (wr_ok),
        .rd_ok  (rd_ok),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .level  (level),
        .empty  (empty),
        .full   (full)
    );

    rxq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (wr_ptr),
        .wdata (wr_word),
        .raddr (rd_ptr),
        .rdata (head_word)
    );

    assign head_err = empty ? '0 : rxq_err_t'(head_word[EW-1 -: ERR_W]);
    assign rd_data  = empty ? '0 : head_word[DATA_W-1:0];
    assign head_brk = head_err.brk;
    assign head_frm = head_err.frm;
    assign head_par = head_err.par;

    rxq_errcnt #(.DEPTH(DEPTH)) u_errcnt (
        .clk (clk),
        .rst (rst),
        .inc (wr_ok && rxq_is_bad(wr_err)),
        .dec (rd_ok && rxq_is_bad(head_err)),
        .cnt (bad_cnt),
        .any (cnt_any)
    );

    assign err_any = cnt_any;

    // R7
    no_err_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> !err_any);

    // R6
    bad_within_level_chk: assert property (@(posedge clk) disable iff (rst)
        bad_cnt <= level);

    // R12
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> empty && !err_any);

endmodule

// File: tb/rx_err_fifo_test.sv
`timescale 1ns/1ps
module rx_err_fifo_test;

    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_brk = 1'b0, wr_frm = 1'b0, wr_par = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       head_brk, head_frm, head_par, err_any, empty, full;
    logic [6:0] level;

    int checks = 0;
    int errors = 0;

    logic [10:0] model [$];

    always #4 clk = ~clk;

    rx_err_fifo uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_brk(wr_brk), .wr_frm(wr_frm), .wr_par(wr_par), .rd_en(rd_en),
        .rd_data(rd_data), .head_brk(head_brk), .head_frm(head_frm),
        .head_par(head_par), .err_any(err_any), .level(level),
        .empty(empty), .full(full)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit model_bad();
        foreach (model[i]) if (model[i][10:8] != 3'b000) return 1'b1;
        return 1'b0;
    endfunction

    task automatic compare_all();
        logic [10:0] hd;
        hd = (model.size() > 0) ? model[0] : 11'd0;
        chk(level == 7'(model.size()), "R11 level", level, model.size());
        chk(empty == (model.size() == 0), "R10 empty", empty, model.size() == 0);
        chk(full == (model.size() == DEPTH), "R9 full", full, model.size() == DEPTH);
        chk(rd_data == hd[7:0], "R2 rd_data", rd_data, hd[7:0]);
        chk({head_brk, head_frm, head_par} == hd[10:8], "R3 head flags",
            {head_brk, head_frm, head_par}, hd[10:8]);
        chk(err_any == model_bad(), "R6 err_any", err_any, model_bad());
    endtask

    task automatic step(input bit w, input logic [7:0] d, input logic [2:0] f, input bit r);
        bit r_ok, w_ok;
        wr_en = w; wr_data = d; {wr_brk, wr_frm, wr_par} = f; rd_en = r;
        r_ok = r && model.size() > 0;
        w_ok = w && model.size() < DEPTH;
        if (r_ok) void'(model.pop_front());
        if (w_ok) model.push_back({f, d});
        @(negedge clk);
        compare_all();
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        model.delete();
        @(negedge clk);
        rst = 1'b0;
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk(level == 0 && empty && !full, "R1 level/empty/full", level, 0);
        chk(!err_any && rd_data == 0, "R1 err_any/data", err_any, 0);

        // R2 ordering of clean characters
        for (int i = 0; i < 5; i++) step(1, 8'(8'h10 + i), 3'b000, 0);
        for (int i = 0; i < 5; i++) begin
            chk(rd_data == 8'(8'h10 + i), "R2 order", rd_data, 8'h10 + i);
            step(0, 0, 0, 1);
        end

        // R3/R4/R7: clean, parity, clean, break+framing, clean
        step(1, 8'hA0, 3'b000, 0);
        step(1, 8'hA1, 3'b001, 0);
        step(1, 8'hA2, 3'b000, 0);
        step(1, 8'hA3, 3'b110, 0);
        step(1, 8'hA4, 3'b000, 0);
        chk(err_any, "R6 set", err_any, 1);
        step(0, 0, 0, 1);
        chk(head_par && !head_brk && rd_data == 8'hA1, "R4 head advance", head_par, 1);
        step(0, 0, 0, 1);
        chk(err_any, "R7 still errored behind", err_any, 1);
        step(0, 0, 0, 1);
        chk(head_brk && head_frm && !head_par, "R3 flags", {head_brk, head_frm, head_par}, 3'b110);
        chk(err_any, "R7 clean reads keep flag", err_any, 1);
        step(0, 0, 0, 1);
        chk(!err_any, "R7 cleared after last", err_any, 0);
        step(0, 0, 0, 1);
        chk(empty && {head_brk, head_frm, head_par} == 0 && rd_data == 0, "R5 empty zero", rd_data, 0);

        // R8 simultaneous errored write and errored read
        step(1, 8'hB0, 3'b010, 0);
        step(1, 8'hB1, 3'b001, 1);
        chk(err_any && level == 1, "R8 hold", level, 1);
        step(0, 0, 0, 1);
        chk(!err_any && empty, "R8 drained", err_any, 0);

        // R9 fill and overflow
        for (int i = 0; i < DEPTH; i++) step(1, 8'(i), 3'(i % 5 == 0 ? 1 : 0), 0);
        chk(full && level == 64, "R9 full", level, 64);
        step(1, 8'hEE, 3'b100, 0);
        chk(level == 64, "R9 drop", level, 64);
        for (int i = 0; i < DEPTH; i++) begin
            chk(rd_data == 8'(i), "R9 no stray", rd_data, i);
            step(0, 0, 0, 1);
        end

        // R10 reads on empty
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1);
        chk(empty && level == 0 && rd_data == 0, "R10 empty read", level, 0);
        step(1, 8'h5A, 3'b000, 1);
        chk(level == 1 && rd_data == 8'h5A, "R10 write with empty read", rd_data, 8'h5A);
        step(0, 0, 0, 1);

        // random traffic with varying fill bias
        for (int ph = 0; ph < 4; ph++) begin
            for (int i = 0; i < 1500; i++) begin
                int wp;
                logic [2:0] fl;
                wp = (ph == 0) ? 80 : (ph == 1) ? 20 : 50;
                fl = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
                step(($urandom_range(0, 99) < wp), 8'($urandom), fl,
                     ($urandom_range(0, 99) < 100 - wp + (ph == 3 ? 20 : 0)));
            end
        end

        // R12 reset mid-run with errored entries
        for (int i = 0; i < 10; i++) step(1, 8'(i), 3'b111, 0);
        chk(err_any, "R12 before", err_any, 1);
        do_reset();
        chk(empty && !err_any && level == 0, "R12 cleared", err_any, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule